// File: doc/BRIEF.md
# Dual-Mode 64b/66b Payload Scrambler

This block scrambles the 64-bit payload of each 66-bit transmit block with a 58-stage linear feedback shift register built on the polynomial x^58 + x^39 + 1. The two header bits of every block go around the scrambler untouched. A static mode input selects one of two ways of using the register. In self-synchronizing mode every scrambled output bit is shifted back into the register, so a receiver locks on after 58 bits whatever its starting state. In synchronous (additive) mode the register runs free from a seed and its keystream is XORed onto the payload.

In synchronous mode a word-type input marks each block. Framing words leave the block unscrambled. Scrambler-state words have their low 58 payload bits overwritten with the live register contents, which lets a far-end descrambler align itself. The register advances 64 steps for every accepted block, whatever the word type. All 64 steps are unrolled into one clock cycle, and the output is registered with one cycle of latency.

A synchronous reset loads the register from the seed input. The seed is expected to be all ones unless a lane needs its own value.

Top module: `scr66_payload_scrambler`

## Requirements
- R1: The 2 header bits of an accepted block appear unchanged on block_o[1:0] one cycle later, in both modes.
- R2: In self-synchronizing mode (mode_i=0), payload bit i is processed in order from i=0 to i=63. Its output is o = p[i] ^ s[38] ^ s[57], and then the state shifts as s = {s[56:0], o}. The scrambled payload appears on block_o[65:2].
- R3: In self-synchronizing mode, a matching descrambler that starts from any state recovers every payload bit from bit 58 of the stream onward.
- R4: While rst is high, the state is loaded from seed_i and valid_o is 0. The first block after reset is scrambled from that seed.
- R5: In synchronous mode (mode_i=1), each bit step computes k = s[38] ^ s[57], sets the output bit to p[i] ^ k, and shifts the state as s = {s[56:0], k}, independent of the data.
- R6: In synchronous mode, a framing word (kind_i=2'b01) leaves the payload unchanged, and the state still advances 64 steps.
- R7: In synchronous mode, a state word (kind_i=2'b10) outputs payload bits [57:0] equal to the state held before that block and keeps payload bits [63:58]. The state then advances 64 steps.
- R8: When valid_i is low, the state does not advance, valid_o goes low on the next cycle and block_o holds its value.
- R9: An accepted block appears on block_o with valid_o high exactly one cycle after it is presented.
- R10: In self-synchronizing mode, kind_i has no effect. In both modes kind_i=2'b11 is treated as data (kind_i=2'b00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads seed |
| mode_i | input | 1 | 0 = self-synchronizing, 1 = synchronous; static |
| seed_i | input | 58 | State value loaded during reset |
| valid_i | input | 1 | Block present this cycle |
| kind_i | input | 2 | 00 data, 01 framing word, 10 state word, 11 data |
| hdr_i | input | 2 | Sync header, passed through |
| payload_i | input | 64 | Payload, bit 0 first |
| valid_o | output | 1 | Output block valid |
| block_o | output | 66 | {payload[63:0], header[1:0]} |

## Verification
The bench compares both modes with a bit-serial model. A wrong tap, a reversed bit order or a feedback of the keystream in place of the output bits would show as a payload mismatch within the first block. Framing and state words are mixed with data words. A design that froze the register on unscrambled words would go wrong on the data word that follows, and one that inserted the state after advancing would carry a wrong state field. Idle gaps between blocks catch a register that advances or an output that changes while nothing is accepted. A descrambler started from the all-zeros state checks that the self-synchronizing output really carries its own key, so a design that used the additive form there would never recover.

// File: rtl/scr66_pkg.sv
package scr66_pkg;
    typedef enum logic {
        MODE_SELF = 1'b0,
        MODE_SYNC = 1'b1
    } scr_mode_e;

    typedef enum logic [1:0] {
        WK_DATA  = 2'b00,
        WK_FRAME = 2'b01,
        WK_STATE = 2'b10,
        WK_RSVD  = 2'b11
    } word_kind_e;
endpackage

// File: rtl/scr66_unroll.sv
// Unrolled PAY_W-step LFSR: self-synchronizing (output fed back) or additive.
module scr66_unroll #(
    parameter int PAY_W  = 64,
    parameter int ST_W   = 58,
    parameter int TAP_LO = 38,
    parameter int TAP_HI = 57
) (
    input  logic             self_sync,
    input  logic [ST_W-1:0]  state_i,
    input  logic [PAY_W-1:0] data_i,
    output logic [PAY_W-1:0] data_o,
    output logic [ST_W-1:0]  state_o
);
    logic [PAY_W:0][ST_W-1:0] chain;
    logic [PAY_W-1:0]         key;

    assign chain[0] = state_i;

    for (genvar i = 0; i < PAY_W; i++) begin : g_step
        assign key[i]      = chain[i][TAP_LO] ^ chain[i][TAP_HI];
        assign data_o[i]   = data_i[i] ^ key[i];
        assign chain[i+1]  = {chain[i][ST_W-2:0], self_sync ? data_o[i] : key[i]};
    end

    assign state_o = chain[PAY_W];
endmodule

// File: rtl/scr66_select.sv
// Chooses the outgoing payload according to mode and word kind.
module scr66_select
    import scr66_pkg::*;
#(
    parameter int PAY_W = 64,
    parameter int ST_W  = 58
) (
    input  logic             sync_mode,
    input  logic [1:0]       kind,
    input  logic [PAY_W-1:0] raw,
    input  logic [PAY_W-1:0] scrambled,
    input  logic [ST_W-1:0]  state,
    output logic [PAY_W-1:0] payload
);
    always_comb begin
        payload = scrambled;
        if (sync_mode) begin
            case (word_kind_e'(kind))
                WK_FRAME: payload = raw;
                WK_STATE: payload = {raw[PAY_W-1:ST_W], state};
                default:  payload = scrambled;
            endcase
        end
    end
endmodule

// File: rtl/scr66_payload_scrambler.sv
module scr66_payload_scrambler
    import scr66_pkg::*;
#(
    parameter int PAY_W  = 64,
    parameter int ST_W   = 58,
    parameter int HDR_W  = 2,
    parameter int TAP_LO = 38,
    parameter int TAP_HI = 57
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode_i,
    input  logic [ST_W-1:0]        seed_i,
    input  logic                   valid_i,
    input  logic [1:0]             kind_i,
    input  logic [HDR_W-1:0]       hdr_i,
    input  logic [PAY_W-1:0]       payload_i,
    output logic                   valid_o,
    output logic [PAY_W+HDR_W-1:0] block_o
);
    localparam int BLK_W = PAY_W + HDR_W;

    typedef struct packed {
        logic [ST_W-1:0]  state;
        logic [BLK_W-1:0] block;
        logic             valid;
    } regs_t;

    regs_t d, q;

    logic [PAY_W-1:0] scr_pay;
    logic [ST_W-1:0]  nxt_state;
    logic [PAY_W-1:0] out_pay;
    logic             sync_mode;

    assign sync_mode = (scr_mode_e'(mode_i) == MODE_SYNC);

    scr66_unroll #(
        .PAY_W(PAY_W), .ST_W(ST_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)
    ) u_unroll (
        .self_sync(!sync_mode),
        .state_i  (q.state),
        .data_i   (payload_i),
        .data_o   (scr_pay),
        .state_o  (nxt_state)
    );

    scr66_select #(.PAY_W(PAY_W), .ST_W(ST_W)) u_select (
        .sync_mode(sync_mode),
        .kind     (kind_i),
        .raw      (payload_i),
        .scrambled(scr_pay),
        .state    (q.state),
        .payload  (out_pay)
    );

    always_comb begin
        d       = q;
        d.valid = valid_i;
        if (valid_i) begin
            d.state = nxt_state;
            d.block = {out_pay, hdr_i};
        end
        if (rst) begin
            d.state = seed_i;
            d.valid = 1'b0;
            d.block = '0;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign valid_o = q.valid;
    assign block_o = q.block;

    // R1: header bypass
    assert_hdr_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> block_o[HDR_W-1:0] == $past(hdr_i));

    // R9: one-cycle latency
    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    // R8: idle cycle holds state and output
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o && $stable(block_o) && $stable(q.state));

    // R6: framing word passes through
    assert_frame_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sync_mode && kind_i == WK_FRAME)
        |=> block_o[BLK_W-1:HDR_W] == $past(payload_i));

    // R7: state word carries pre-block state
    assert_state_ins_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sync_mode && kind_i == WK_STATE)
        |=> block_o[ST_W+HDR_W-1:HDR_W] == $past(q.state));
endmodule

// File: tb/tb_scr66_payload_scrambler.sv
module tb_scr66_payload_scrambler;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_i;
    logic [57:0] seed_i;
    logic        valid_i;
    logic [1:0]  kind_i;
    logic [1:0]  hdr_i;
    logic [63:0] payload_i;
    logic        valid_o;
    logic [65:0] block_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [57:0] m_st;
    logic        m_mode;
    logic [63:0] lcg = 64'h0123_4567_89ab_cdef;

    always #(CLK_PERIOD/2) clk = ~clk;

    scr66_payload_scrambler dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .seed_i(seed_i),
        .valid_i(valid_i), .kind_i(kind_i), .hdr_i(hdr_i),
        .payload_i(payload_i), .valid_o(valid_o), .block_o(block_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [65:0] act, input logic [65:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg ^ (lcg >> 29);
    endfunction

    // Bit-serial reference, written from R2, R5, R6, R7, R10
    task automatic model_block(input logic [1:0] kind, input logic [63:0] p,
                               output logic [63:0] o);
        logic [57:0] s0;
        logic [63:0] scr;
        logic        k;
        s0 = m_st;
        for (int i = 0; i < 64; i++) begin
            if (m_mode == 1'b0) begin
                k = p[i] ^ m_st[38] ^ m_st[57];
                scr[i] = k;
            end else begin
                k = m_st[38] ^ m_st[57];
                scr[i] = p[i] ^ k;
            end
            m_st = {m_st[56:0], k};
        end
        o = scr;
        if (m_mode == 1'b1 && kind == 2'b01) o = p;
        if (m_mode == 1'b1 && kind == 2'b10) o = {p[63:58], s0};
    endtask

    task automatic do_reset(input logic mode, input logic [57:0] seed);
        @(negedge clk);
        rst = 1'b1; mode_i = mode; seed_i = seed; valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(valid_o == 1'b0, "R4 valid low in reset", {65'd0, valid_o}, 66'd0);
        rst = 1'b0;
        m_st = seed; m_mode = mode;
    endtask

    // Drive one block (called just after a negedge), check at next negedge
    task automatic send(input logic [1:0] kind, input logic [1:0] hdr,
                        input logic [63:0] p, input string req,
                        output logic [63:0] got);
        logic [63:0] exp;
        valid_i = 1'b1; kind_i = kind; hdr_i = hdr; payload_i = p;
        model_block(kind, p, exp);
        @(negedge clk);
        valid_i = 1'b0;
        check(valid_o == 1'b1, {req, " R9 valid_o"}, {65'd0, valid_o}, 66'd1);
        check(block_o == {exp, hdr}, req, block_o, {exp, hdr});
        got = block_o[65:2];
    endtask

    task automatic t_reset_seed();
        logic [63:0] g;
        logic [63:0] p;
        do_reset(1'b1, 58'h2a5_5a5a_1234_beef);
        p = 64'hfc00_0000_0000_0000;
        send(2'b10, 2'b10, p, "R4 seed via state word", g);
        check(g[57:0] == 58'h2a5_5a5a_1234_beef, "R4 seed loaded",
              {8'd0, g[57:0]}, {8'd0, 58'h2a5_5a5a_1234_beef});
        check(g[63:58] == 6'h3f, "R7 upper bits kept", {60'd0, g[63:58]}, 66'h3f);
    endtask

    task automatic t_self_sync();
        logic [63:0] g;
        do_reset(1'b0, {58{1'b1}});
        send(2'b00, 2'b01, 64'd0, "R2 zero payload", g);
        send(2'b00, 2'b10, 64'hffff_ffff_ffff_ffff, "R2 ones payload", g);
        for (int i = 0; i < 6; i++)
            send(2'b00, 2'(i), next_rand(), "R2 R1 random", g);
        send(2'b01, 2'b01, next_rand(), "R10 frame kind ignored self", g);
        send(2'b10, 2'b10, next_rand(), "R10 state kind ignored self", g);
        send(2'b00, 2'b01, next_rand(), "R2 after ignored kinds", g);
    endtask

    task automatic t_sync_mode();
        logic [63:0] g;
        logic [63:0] p;
        do_reset(1'b1, 58'h155_0f0f_cafe_0001);
        send(2'b00, 2'b01, 64'd0, "R5 keystream", g);
        p = next_rand();
        send(2'b01, 2'b10, p, "R6 frame word", g);
        check(g == p, "R6 frame unchanged", {2'b0, g}, {2'b0, p});
        send(2'b00, 2'b01, next_rand(), "R6 advance after frame", g);
        send(2'b10, 2'b10, next_rand(), "R7 state word", g);
        send(2'b00, 2'b01, next_rand(), "R7 advance after state", g);
        send(2'b11, 2'b01, next_rand(), "R10 reserved as data", g);
        send(2'b10, 2'b10, next_rand(), "R7 second state word", g);
    endtask

    task automatic t_stall();
        logic [63:0] g;
        logic [65:0] held;
        do_reset(1'b0, 58'h0ab_cdef_0123_4567);
        send(2'b00, 2'b01, next_rand(), "R8 before gap", g);
        held = block_o;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(valid_o == 1'b0, "R8 valid_o low", {65'd0, valid_o}, 66'd0);
            check(block_o == held, "R8 block held", block_o, held);
        end
        send(2'b00, 2'b10, next_rand(), "R8 no advance in gap", g);
        @(negedge clk);
        send(2'b00, 2'b01, next_rand(), "R8 after single gap", g);
    endtask

    task automatic t_recover();
        logic [63:0] g;
        logic [63:0] p;
        logic [63:0] rec;
        logic [57:0] ds;
        do_reset(1'b0, {58{1'b1}});
        ds = '0;
        for (int b = 0; b < 3; b++) begin
            p = next_rand();
            send(2'b00, 2'b01, p, "R3 tx block", g);
            for (int i = 0; i < 64; i++) begin
                rec[i] = g[i] ^ ds[38] ^ ds[57];
                ds = {ds[56:0], g[i]};
            end
            if (b == 0)
                check(rec[63:58] == p[63:58], "R3 tail of first block",
                      {60'd0, rec[63:58]}, {60'd0, p[63:58]});
            else
                check(rec == p, "R3 recovered block", {2'b0, rec}, {2'b0, p});
        end
    endtask

    initial begin
        rst = 1'b1; mode_i = 1'b0; seed_i = '1; valid_i = 1'b0;
        kind_i = 2'b00; hdr_i = 2'b00; payload_i = '0;
        t_reset_seed();
        t_self_sync();
        t_sync_mode();
        t_stall();
        t_recover();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule